// File: doc/BRIEF.md
# 16550-Compatible UART Register Emulator

This block presents a byte-wide register file that a CPU sees as a 16550A-style UART, reached over a simple request/acknowledge bus. No serial bits are shifted and no baud clock is produced. Each direction holds exactly one byte. A byte the CPU writes to the transmit holding register leaves on a valid/ready stream towards a debug host. A byte offered by the host on a second valid/ready stream is kept in the receive buffer until the CPU reads it.

Only a subset of the 16550 register set is implemented. The implemented registers are the receive buffer and transmit holding register, the interrupt enable and identification registers, the line control register with its divisor-latch access bit, two divisor latch bytes and the line status register. Unimplemented addresses ignore writes and read as zero. The block also drives a level interrupt output that follows the interrupt identification code.

Top module: `uart_emu`

## Requirements
- R1: After reset, reads return 0x00 at address 0 (receive buffer), 0x00 at address 1 (interrupt enable), 0x01 at address 2 (interrupt identification), 0x00 at address 3 (line control) and 0x60 at address 5 (line status). irq_o and tx_valid_o are 0 and rx_ready_o is 1.
- R2: The block accepts a request on a clock edge where bus_req_i is 1 and bus_ack_o is 0. bus_ack_o is 1 for exactly the following cycle. On a read, bus_rdata_o carries the register value in that cycle.
- R3: A write to address 0 while line control bit 7 is 0 and the transmit byte is empty puts the byte on tx_data_o with tx_valid_o set. tx_data_o holds until a cycle with tx_ready_i set. Until then, line status bits 5 and 6 read 0 (line status 0x00 with no receive byte pending). After the handshake they read 1 again.
- R4: A host byte is taken on a cycle where rx_valid_i and rx_ready_o are both 1. After that, rx_ready_o is 0 and line status bit 0 is 1. A read of address 0 while line control bit 7 is 0 returns the byte, clears bit 0 and raises rx_ready_o again.
- R5: Address 1 is a read/write register that keeps all 8 written bits. Bit 0 enables the receive interrupt and bit 1 enables the transmit-empty interrupt.
- R6: Address 3 keeps all 8 written bits. While its bit 7 is 1, addresses 0 and 1 read and write the low and high divisor latch bytes. Those accesses leave the transmit path, the receive buffer and the interrupt enable register untouched.
- R7: Address 2 reads 0x04 when interrupt enable bit 0 is set and a receive byte is pending. Otherwise it reads 0x02 when enable bit 1 is set and the transmit byte is empty. Otherwise it reads 0x01.
- R8: irq_o is 1 exactly when the interrupt identification code has bit 0 clear.
- R9: Writes to address 2, 4, 5, 6 or 7 change no readable register. Reads of addresses 4, 6 and 7 return 0x00.
- R10: A transmit holding write while a byte is still waiting for tx_ready_i is dropped, and the waiting byte is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | CPU request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_ack_o | output | 1 | Request done, one cycle |
| bus_rdata_o | output | 8 | Read data, valid with bus_ack_o |
| tx_data_o | output | 8 | Byte towards the host |
| tx_valid_o | output | 1 | tx_data_o holds a byte |
| tx_ready_i | input | 1 | Host takes the byte |
| rx_data_i | input | 8 | Byte from the host |
| rx_valid_i | input | 1 | rx_data_i holds a byte |
| rx_ready_o | output | 1 | Receive buffer free |
| irq_o | output | 1 | Interrupt request, level |

## Verification
A vector table runs write/read pairs across every address, both with the divisor-latch bit set and with it clear. This separates storage, aliasing and ignored writes: the same address has to return the divisor byte in one mode and the enable register in the other. Directed sequences then start a transmit and hold tx_ready_i low while a second write arrives. This tells a dropped overwrite apart from a replaced byte. Host bytes are offered while the buffer is already full, which shows whether the block back-pressures or overwrites. Each interrupt enable combination is paired with pending-receive and empty-transmit states, so that the priority order and the irq level can be seen.

// File: rtl/uart_emu_pkg.sv
package uart_emu_pkg;
  localparam int unsigned ADR_DATA = 0;
  localparam int unsigned ADR_IEN  = 1;
  localparam int unsigned ADR_IID  = 2;
  localparam int unsigned ADR_LCTL = 3;
  localparam int unsigned ADR_LSTS = 5;

  localparam int unsigned IID_NONE = 8'h01;
  localparam int unsigned IID_TXE  = 8'h02;
  localparam int unsigned IID_RXD  = 8'h04;

  localparam int unsigned LS_DR   = 0;
  localparam int unsigned LS_THRE = 5;
  localparam int unsigned LS_TEMT = 6;
endpackage

// File: rtl/uart_emu_regs.sv
module uart_emu_regs
  import uart_emu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_ack_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [DATA_W-1:0] rbr_i,
  input  logic [DATA_W-1:0] lsr_i,
  input  logic [DATA_W-1:0] iir_i,
  output logic              thr_wr_o,
  output logic              rbr_rd_o,
  output logic [DATA_W-1:0] ier_o,
  output logic [DATA_W-1:0] lcr_o
);
  logic              ack_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic [DATA_W-1:0] ier_q, lcr_q, dll_q, dlm_q;
  logic              acc, wr, rd, dlab;
  logic              hit_dat, hit_ien, hit_iid, hit_lct, hit_lst;

  assign acc  = bus_req_i & ~ack_q;
  assign wr   = acc & bus_we_i;
  assign rd   = acc & ~bus_we_i;
  assign dlab = lcr_q[DATA_W-1];

  assign hit_dat = (bus_addr_i == ADDR_W'(ADR_DATA));
  assign hit_ien = (bus_addr_i == ADDR_W'(ADR_IEN));
  assign hit_iid = (bus_addr_i == ADDR_W'(ADR_IID));
  assign hit_lct = (bus_addr_i == ADDR_W'(ADR_LCTL));
  assign hit_lst = (bus_addr_i == ADDR_W'(ADR_LSTS));

  assign thr_wr_o = wr & hit_dat & ~dlab;
  assign rbr_rd_o = rd & hit_dat & ~dlab;

  always_comb begin
    rd_mux = '0;
    if (hit_dat)      rd_mux = dlab ? dll_q : rbr_i;
    else if (hit_ien) rd_mux = dlab ? dlm_q : ier_q;
    else if (hit_iid) rd_mux = iir_i;
    else if (hit_lct) rd_mux = lcr_q;
    else if (hit_lst) rd_mux = lsr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
      ier_q   <= '0;
      lcr_q   <= '0;
      dll_q   <= '0;
      dlm_q   <= '0;
    end else begin
      ack_q <= acc;
      if (rd) rdata_q <= rd_mux;
      if (wr) begin
        if (hit_dat && dlab)  dll_q <= bus_wdata_i;
        if (hit_ien && dlab)  dlm_q <= bus_wdata_i;
        if (hit_ien && !dlab) ier_q <= bus_wdata_i;
        if (hit_lct)          lcr_q <= bus_wdata_i;
      end
    end
  end

  assign bus_ack_o   = ack_q;
  assign bus_rdata_o = rdata_q;
  assign ier_o       = ier_q;
  assign lcr_o       = lcr_q;
endmodule

// File: rtl/uart_emu_tx.sv
module uart_emu_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              thr_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tx_ready_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] thr_q;
  logic              full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= '0;
      full_q <= 1'b0;
    end else if (full_q) begin
      if (tx_ready_i) full_q <= 1'b0;  // overwrite while full is dropped
    end else if (thr_wr_i) begin
      thr_q  <= wdata_i;
      full_q <= 1'b1;
    end
  end

  assign tx_data_o  = thr_q;
  assign tx_valid_o = full_q;
  assign empty_o    = ~full_q;
endmodule

// File: rtl/uart_emu_rx.sv
module uart_emu_rx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rbr_rd_i,
  output logic              rx_ready_o,
  output logic [DATA_W-1:0] rbr_o,
  output logic              dr_o
);
  logic [DATA_W-1:0] rbr_q;
  logic              dr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbr_q <= '0;
      dr_q  <= 1'b0;
    end else if (dr_q) begin
      if (rbr_rd_i) dr_q <= 1'b0;
    end else if (rx_valid_i) begin
      rbr_q <= rx_data_i;
      dr_q  <= 1'b1;
    end
  end

  assign rx_ready_o = ~dr_q;
  assign rbr_o      = rbr_q;
  assign dr_o       = dr_q;
endmodule

// File: rtl/uart_emu_irq.sv
module uart_emu_irq
  import uart_emu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              rx_en_i,
  input  logic              tx_en_i,
  input  logic              dr_i,
  input  logic              thre_i,
  output logic [DATA_W-1:0] iir_o,
  output logic              irq_o
);
  always_comb begin
    if (rx_en_i && dr_i)        iir_o = DATA_W'(IID_RXD);
    else if (tx_en_i && thre_i) iir_o = DATA_W'(IID_TXE);
    else                        iir_o = DATA_W'(IID_NONE);
  end
  assign irq_o = ~iir_o[0];
endmodule

// File: rtl/uart_emu.sv
module uart_emu
  import uart_emu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_ack_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic              irq_o
);
  logic              thr_wr, rbr_rd, thr_empty, dr;
  logic [DATA_W-1:0] ier_q, lcr_q, rbr, lsr, iir;

  always_comb begin
    lsr          = '0;
    lsr[LS_DR]   = dr;
    lsr[LS_THRE] = thr_empty;
    lsr[LS_TEMT] = thr_empty;  // no shifter: empty holding reg means idle line
  end

  uart_emu_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .bus_req_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .bus_ack_o, .bus_rdata_o,
    .rbr_i(rbr), .lsr_i(lsr), .iir_i(iir),
    .thr_wr_o(thr_wr), .rbr_rd_o(rbr_rd), .ier_o(ier_q), .lcr_o(lcr_q)
  );

  uart_emu_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni, .thr_wr_i(thr_wr), .wdata_i(bus_wdata_i),
    .tx_ready_i, .tx_data_o, .tx_valid_o, .empty_o(thr_empty)
  );

  uart_emu_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .rx_valid_i, .rx_data_i, .rbr_rd_i(rbr_rd),
    .rx_ready_o, .rbr_o(rbr), .dr_o(dr)
  );

  uart_emu_irq #(.DATA_W(DATA_W)) u_irq (
    .rx_en_i(ier_q[0]), .tx_en_i(ier_q[1]), .dr_i(dr), .thre_i(thr_empty),
    .iir_o(iir), .irq_o
  );
endmodule

// File: rtl/uart_emu_chk.sv
module uart_emu_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_ack_o,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] ier_q,
  input logic              dr,
  input logic              thr_empty
);
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ack_o |=> !bus_ack_o);  // R2
  AST_ACK_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_i && !bus_ack_o |=> !bus_ack_o);  // R2
  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));  // R3
  AST_TX_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i |=> !tx_valid_o);  // R3
  AST_RX_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && rx_ready_o |=> !rx_ready_o);  // R4
  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((ier_q[0] && dr) || (ier_q[1] && thr_empty)));  // R8
endmodule

bind uart_emu uart_emu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .bus_req_i, .bus_ack_o, .tx_data_o, .tx_valid_o,
  .tx_ready_i, .rx_valid_i, .rx_ready_o, .irq_o,
  .ier_q(ier_q), .dr(dr), .thr_empty(thr_empty)
);

// File: tb/uart_emu_test.sv
`timescale 1ns/1ps
module uart_emu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       ack;
  logic [7:0] rdata, tx_data;
  logic       tx_valid, tx_ready = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 1'b0, rx_ready, irq;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  uart_emu uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_ack_o(ack), .bus_rdata_o(rdata),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .irq_o(irq)
  );

  // {we, addr, wdata, expected read}
  localparam int NV = 22;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 3'd3, 8'h1B, 8'h00}, {1'b0, 3'd3, 8'h00, 8'h1B},  // R6 lcr store
    {1'b1, 3'd1, 8'hA0, 8'h00}, {1'b0, 3'd1, 8'h00, 8'hA0},  // R5
    {1'b1, 3'd4, 8'h55, 8'h00}, {1'b0, 3'd4, 8'h00, 8'h00},  // R9
    {1'b1, 3'd7, 8'h33, 8'h00}, {1'b0, 3'd7, 8'h00, 8'h00},  // R9
    {1'b1, 3'd6, 8'hFF, 8'h00}, {1'b0, 3'd6, 8'h00, 8'h00},  // R9
    {1'b1, 3'd2, 8'hFF, 8'h00}, {1'b0, 3'd2, 8'h00, 8'h01},  // R9/R7
    {1'b1, 3'd5, 8'h00, 8'h00}, {1'b0, 3'd5, 8'h00, 8'h60},  // R9
    {1'b1, 3'd3, 8'h80, 8'h00}, {1'b1, 3'd0, 8'h12, 8'h00},  // R6 dlab
    {1'b1, 3'd1, 8'h34, 8'h00}, {1'b0, 3'd0, 8'h00, 8'h12},  // R6
    {1'b0, 3'd1, 8'h00, 8'h34}, {1'b1, 3'd3, 8'h03, 8'h00},  // R6
    {1'b0, 3'd1, 8'h00, 8'hA0}, {1'b0, 3'd5, 8'h00, 8'h60}   // R6 untouched
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic [2:0] a, input logic [7:0] d,
                      output logic [7:0] r, output logic ack_seen);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    ack_seen = ack;
    r = rdata;
    req = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] r);
    logic k;
    xfer(1'b0, a, 8'h00, r, k);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] r;
    logic k;
    xfer(1'b1, a, d, r, k);
  endtask

  task automatic host_send(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    logic k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
    chk("R1 rx_ready", {7'd0, rx_ready}, 8'h01);
    rd(3'd0, r); chk("R1 rbr", r, 8'h00);
    rd(3'd1, r); chk("R1 ier", r, 8'h00);
    rd(3'd2, r); chk("R1 iir", r, 8'h01);
    rd(3'd3, r); chk("R1 lcr", r, 8'h00);
    rd(3'd5, r); chk("R1 lsr", r, 8'h60);

    // R2 handshake timing
    xfer(1'b0, 3'd5, 8'h00, r, k);
    chk("R2 ack with data", {7'd0, k}, 8'h01);
    chk("R2 rdata", r, 8'h60);
    @(negedge clk);
    chk("R2 ack drops", {7'd0, ack}, 8'h00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][19], VEC[i][18:16], VEC[i][15:8], r, k);
      if (!VEC[i][19]) chk("R5/R6/R9 vector", r, VEC[i][7:0]);
    end
    chk("R6 no tx from divisor write", {7'd0, tx_valid}, 8'h00);

    // R3 / R10 transmit path
    wr(3'd0, 8'hA5);
    chk("R3 tx_valid", {7'd0, tx_valid}, 8'h01);
    chk("R3 tx_data", tx_data, 8'hA5);
    rd(3'd5, r); chk("R3 lsr busy", r, 8'h00);
    wr(3'd0, 8'h3C);
    chk("R10 kept byte", tx_data, 8'hA5);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R3 tx released", {7'd0, tx_valid}, 8'h00);
    rd(3'd5, r); chk("R3 lsr idle", r, 8'h60);
    chk("R10 no resend", {7'd0, tx_valid}, 8'h00);

    // R4 receive path
    host_send(8'h77);
    chk("R4 rx_ready low", {7'd0, rx_ready}, 8'h00);
    rd(3'd5, r); chk("R4 lsr dr", r, 8'h61);
    host_send(8'h88);
    rd(3'd0, r); chk("R4 rbr keeps first", r, 8'h77);
    chk("R4 rx_ready high", {7'd0, rx_ready}, 8'h01);
    rd(3'd5, r); chk("R4 dr clear", r, 8'h60);

    // R7 / R8 interrupt identification
    host_send(8'h5A);
    wr(3'd1, 8'h03);
    rd(3'd2, r); chk("R7 rx priority", r, 8'h04);
    chk("R8 irq rx", {7'd0, irq}, 8'h01);
    rd(3'd0, r); chk("R4 second byte", r, 8'h5A);
    rd(3'd2, r); chk("R7 tx empty", r, 8'h02);
    chk("R8 irq tx", {7'd0, irq}, 8'h01);
    wr(3'd1, 8'h01);
    rd(3'd2, r); chk("R7 none", r, 8'h01);
    chk("R8 irq off", {7'd0, irq}, 8'h00);
    wr(3'd1, 8'h02);
    wr(3'd0, 8'hC3);
    rd(3'd2, r); chk("R7 tx busy none", r, 8'h01);
    chk("R8 irq off busy", {7'd0, irq}, 8'h00);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R8 irq after drain", {7'd0, irq}, 8'h01);

    finish_run();
  end
endmodule